// File: doc/BRIEF.md
# Blinking LED Duty Controller

This block drives one LED pin from a small word-addressed register set. A two-bit mode field selects the output behaviour: held low, held high, or a periodic blink whose on-time is a fraction of the period. The block runs from one system clock. A slow time-base enable, nominally 32768 pulses per second, qualifies every step of the blink timing.

In blink mode a 12-bit prescale counter divides the tick enable. Each time the prescaler completes, an 8-bit phase counter advances by one, so a full blink period is 256 × (prescale + 1) ticks. The LED is lit while the phase counter is below the programmed duty byte. Timing registers are written into a staging copy. The copy in use is refreshed only after software requests an update, and the refresh happens at the end of a blink period, so a period is never cut short. A soft-reset bit restarts the phase from zero at once.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset, word 0 reads 0x00001400, words 1 and 2 read 0, and the LED output is low.
- R2: The mode field, word 0 bits [1:0], takes effect on the write. Value 0 drives the LED low and value 3 drives it high. Value 1 also drives the LED low. In every mode other than 2, the prescaler and phase counter are held at zero, so blinking always starts from phase 0.
- R3: In mode 2 the prescaler counts 0 to P, where P is the in-use value of word 2 bits [11:0], on each cycle the tick input is high. The phase counter advances once per P+1 ticks and wraps from 255 to 0. Cycles without a tick change nothing.
- R4: In mode 2 the LED is high while the phase is below the in-use duty byte, word 1 bits [7:0]. Duty 0x00 keeps it always low and duty 0xFF keeps it always high.
- R5: Writes to words 1 and 2 change only the staged copy, which reads back at once. The output keeps using the previous values until an update loads them.
- R6: Writing 1 to word 0 bit 6 requests a load of the staged values. In mode 2 the load happens at the next phase wrap. In any other mode it happens on the following cycle. Bit 6 reads 1 while the load is pending and clears itself once the load is done.
- R7: Writing 1 to word 0 bit 7 zeroes the prescaler and phase counter on that write. The bit always reads 0, and the other fields of the same write are stored normally.
- R8: Word 0 bits [5:2] and [15:8], word 1 bits [15:8], and word 2 bits [23:12] are stored and read back, and they have no effect on the LED.
- R9: Word address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, one cycle per slow tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (staged values) |
| led_o | output | 1 | LED drive |

## Verification
The assertions assume that tick and the write strobe are clean single-cycle, synchronous levels. They also assume that the in-use prescale value changes only through the block's own load path, so the prescaler never starts above its limit. The bench meets these assumptions by driving every input on the falling clock edge. It reprograms timing only through staged writes followed by an update request. For the duty and period sweeps, it makes the first load in a non-blink mode, so each measured window starts from phase zero. Blink measurements count lit cycles over whole periods, so the expected value is a pure product of duty, prescale and tick spacing, whatever the phase.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int PRE_W  = 12;
    localparam int CNT_W  = 8;
    localparam int WDT_W  = 8;

    localparam logic [ADDR_W-1:0] A_CFG   = 2'd0;
    localparam logic [ADDR_W-1:0] A_LIMIT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DELAY = 2'd2;

    localparam int UPD_BIT  = 6;
    localparam int SRST_BIT = 7;
    localparam logic [WDT_W-1:0] WDT_RST = 8'h14;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_BREATH = 2'd1,
        MODE_BLINK  = 2'd2,
        MODE_ON     = 2'd3
    } led_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] top_lvl;
        logic [PRE_W-1:0] presc;
        logic [PRE_W-1:0] presc_alt;
    } timing_set_t;

    function automatic logic [DATA_W-1:0] pack_limit(timing_set_t s);
        pack_limit = '0;
        pack_limit[2*CNT_W-1:0] = {s.top_lvl, s.duty};
    endfunction

    function automatic logic [DATA_W-1:0] pack_delay(timing_set_t s);
        pack_delay = '0;
        pack_delay[2*PRE_W-1:0] = {s.presc_alt, s.presc};
    endfunction
endpackage

// File: rtl/led_regs.sv
module led_regs
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    output logic [DATA_W-1:0] rdata,
    output led_mode_e         mode,
    output timing_set_t       live,
    output logic              srst
);
    logic        cfg_wr, upd_pend, load;
    logic [3:0]  spare;
    logic [WDT_W-1:0] wdt;
    timing_set_t stage;

    assign cfg_wr = wr_en && (addr == A_CFG);
    assign srst   = cfg_wr && wdata[SRST_BIT];
    assign load   = upd_pend && ((mode != MODE_BLINK) || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_OFF;
            spare    <= '0;
            wdt      <= WDT_RST;
            upd_pend <= 1'b0;
            stage    <= '0;
            live     <= '0;
        end else begin
            if (load) live <= stage;
            upd_pend <= (upd_pend && !load) || (cfg_wr && wdata[UPD_BIT]);
            if (cfg_wr) begin
                mode  <= led_mode_e'(wdata[1:0]);
                spare <= wdata[5:2];
                wdt   <= wdata[8 +: WDT_W];
            end
            if (wr_en && addr == A_LIMIT) begin
                stage.duty    <= wdata[CNT_W-1:0];
                stage.top_lvl <= wdata[CNT_W +: CNT_W];
            end
            if (wr_en && addr == A_DELAY) begin
                stage.presc     <= wdata[PRE_W-1:0];
                stage.presc_alt <= wdata[PRE_W +: PRE_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata[15:0] = {wdt, 1'b0, upd_pend, spare, mode};
            A_LIMIT: rdata = pack_limit(stage);
            A_DELAY: rdata = pack_delay(stage);
            default: rdata = '0;
        endcase
    end

    // R6: a completed load leaves no request pending unless a new one arrives
    p_upd_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (load && !(cfg_wr && wdata[UPD_BIT])) |=> !upd_pend);
    // R5: in-use values move only on a load
    p_live_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(live));
endmodule

// File: rtl/led_timebase.sv
module led_timebase
    import led_blink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] phase,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] PHASE_MAX = '1;

    logic [PRE_W-1:0] pcnt;
    logic             pre_done;

    assign pre_done = (pcnt == presc);
    assign wrap     = run && !clr && tick && pre_done && (phase == PHASE_MAX);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            pcnt  <= '0;
            phase <= '0;
        end else if (tick) begin
            if (pre_done) begin
                pcnt  <= '0;
                phase <= phase + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // R2: counters parked at zero outside blink mode
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0 && pcnt == '0));
    // R3: prescaler never runs past its limit
    p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
        pcnt <= presc);
    // R3: no tick, no movement
    p_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && !tick) |=> $stable(phase));
    // R3: wrap returns the phase to zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase == '0));
    // R7: soft reset zeroes both counters
    p_srst_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (phase == '0 && pcnt == '0));
endmodule

// File: rtl/led_drive.sv
module led_drive
    import led_blink_pkg::*;
(
    input  led_mode_e        mode,
    input  logic [CNT_W-1:0] phase,
    input  logic [CNT_W-1:0] duty,
    output logic             led
);
    localparam logic [CNT_W-1:0] DUTY_FULL = '1;

    always_comb begin
        unique case (mode)
            MODE_ON:    led = 1'b1;
            MODE_BLINK: led = (duty == DUTY_FULL) || (phase < duty);
            default:    led = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              led_o
);
    led_mode_e        mode;
    timing_set_t      live;
    logic             srst, wrap;
    logic [CNT_W-1:0] phase;

    led_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wrap(wrap), .rdata(rdata), .mode(mode), .live(live), .srst(srst)
    );

    led_timebase u_tb (
        .clk(clk), .rst(rst), .tick(tick), .run(mode == MODE_BLINK),
        .clr(srst), .presc(live.presc), .phase(phase), .wrap(wrap)
    );

    led_drive u_drv (
        .mode(mode), .phase(phase), .duty(live.duty), .led(led_o)
    );

    // R2: low in off and breathing codes
    p_low_modes_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF || mode == MODE_BREATH) |-> !led_o);
    // R2: high in the always-on code
    p_high_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ON) |-> led_o);
    // R4: zero duty never lights the LED
    p_zero_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (live.duty == '0) |-> (!led_o || mode == MODE_ON));
endmodule

// File: tb/tb_led_blink_ctrl.sv
module tb_led_blink_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        led_o;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tcnt = 0;

    led_blink_ctrl dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .led_o(led_o)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick <= 1'b1;
            tcnt <= 0;
        end else begin
            tick <= (tcnt == 0);
            tcnt <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
        end
    end

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic lit_count(int n, output int hc);
        hc = 0;
        for (int i = 0; i < n; i++) begin
            if (led_o) hc++;
            @(negedge clk);
        end
    endtask

    task automatic run_len(output int rl);
        rl = 0;
        while (led_o && rl < 5000) begin
            rl++;
            @(negedge clk);
        end
    endtask

    task automatic start_blink(int p, int d);
        wr(2'd2, p);
        wr(2'd1, d);
        wr(2'd0, 32'h0000_1440);
        wr(2'd0, 32'h0000_1402);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hc, rl, exp;
        int plist[4];
        int dlist[7];
        plist = '{0, 1, 2, 3};
        dlist = '{0, 1, 2, 127, 128, 254, 255};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd("R1 cfg", 2'd0, 32'h0000_1400);
        rd("R1 limit", 2'd1, 32'h0);
        rd("R1 delay", 2'd2, 32'h0);
        check("R1 led", led_o, 0);

        // R2 fixed modes
        wr(2'd0, 32'h0000_1403);
        check("R2 mode3 high", led_o, 1);
        wr(2'd0, 32'h0000_1401);
        check("R2 mode1 low", led_o, 0);
        wr(2'd0, 32'h0000_1400);
        check("R2 mode0 low", led_o, 0);

        // R2 blink starts from phase zero: first lit run equals duty
        start_blink(0, 5);
        run_len(rl);
        check("R2 phase starts at zero", rl, 5);

        // R3 R4 sweep of prescale and duty over full periods
        foreach (plist[pi]) begin
            foreach (dlist[di]) begin
                start_blink(plist[pi], dlist[di]);
                exp = (dlist[di] == 255) ? 256 * (plist[pi] + 1)
                                         : dlist[di] * (plist[pi] + 1);
                lit_count(256 * (plist[pi] + 1), hc);
                check($sformatf("R3 R4 P=%0d D=%0d", plist[pi], dlist[di]), hc, exp);
            end
        end

        // R3 tick spacing of three cycles
        tick_div = 3;
        start_blink(3, 100);
        lit_count(3 * 256 * 4, hc);
        check("R3 sparse tick", hc, 3 * 100 * 4);
        tick_div = 1;

        // R5 staged values do not reach the output
        start_blink(0, 40);
        wr(2'd1, 32'd100);
        rd("R5 staged readback", 2'd1, 32'd100);
        lit_count(256, hc);
        check("R5 output unchanged", hc, 40);

        // R6 update request pending until wrap, then self-clearing
        wr(2'd0, 32'h0000_1442);
        rd("R6 pending bit", 2'd0, 32'h0000_1442);
        repeat (260) @(negedge clk);
        rd("R6 bit cleared", 2'd0, 32'h0000_1402);
        lit_count(256, hc);
        check("R6 new duty in use", hc, 100);

        // R7 soft reset restarts the phase
        start_blink(0, 128);
        while (led_o) @(negedge clk);
        wr(2'd0, 32'h0000_1482);
        run_len(rl);
        check("R7 lit run after soft reset", rl, 128);
        rd("R7 bit reads zero", 2'd0, 32'h0000_1402);

        // R8 storage-only fields
        wr(2'd1, 32'h0000_AB64);
        wr(2'd2, 32'h00AB_C001);
        wr(2'd0, 32'h0000_5A7E);
        repeat (520) @(negedge clk);
        rd("R8 cfg fields", 2'd0, 32'h0000_5A3E);
        rd("R8 limit upper", 2'd1, 32'h0000_AB64);
        rd("R8 delay upper", 2'd2, 32'h00AB_C001);
        lit_count(512, hc);
        check("R8 no effect on output", hc, 200);

        // R9 unused address
        rd("R9 read zero", 2'd3, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd("R9 cfg untouched", 2'd0, 32'h0000_5A3E);
        rd("R9 limit untouched", 2'd1, 32'h0000_AB64);
        rd("R9 delay untouched", 2'd2, 32'h00AB_C001);
        lit_count(512, hc);
        check("R9 output untouched", hc, 200);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule